// File: doc/BRIEF.md
# Processor Status Word and Banked Stack Pointer Unit

This block keeps the status word of a CPU core together with the small set of dedicated registers that depend on it. The status word has three fields: a condition-code byte (carry, overflow, zero, negative, interrupt enable and stack select), a three-bit system-condition field (a trace bit and two divide-step bits) and a five-bit interrupt-level mask. Software reaches the fields through one full-word port or through a separate byte port for each field. The execute stage updates the four arithmetic flags through individual enables.

The block also owns the live stack-pointer slot of the register file and two banked stack pointers, one for system mode and one for user mode. The stack-select flag picks which bank is live. Whenever a write changes that flag, the live pointer is saved into the bank being left and reloaded from the bank being entered, in a single clock. A dedicated-register port, indexed by number, reaches the table base, the return pointer, the multiply/divide high and low words and both stack pointers. The stack-pointer entry that is currently live is routed to the live slot.

Top module: `cpu_status_bank`

## Requirements
- R1: The condition-code port reads {2'b00, stack select [5], interrupt enable [4], negative [3], zero [2], overflow [1], carry [0]}; a condition-code byte write stores only bits 5:0.
- R2: The system-condition port reads {5'b0, divide-step 1 [2], divide-step 0 [1], trace [0]}; a write stores only bits 2:0.
- R3: The status word reads condition codes in 7:0, the system-condition field in 10:8 and the level mask in 20:16, with zeros elsewhere; a status-word write loads all three fields from those positions in one clock.
- R4: A level-mask write (byte port bits 4:0 or word bits 20:16) stores 5 bits; when the stored mask is 16 or more and the new value is below 16, the value stored is the new value plus 16.
- R5: When a write takes stack select from 1 to 0, the live stack pointer is copied into the user bank and loaded from the system bank in the same clock.
- R6: When a write takes stack select from 0 to 1, the live stack pointer is copied into the system bank and loaded from the user bank; a write that leaves stack select unchanged causes no swap.
- R7: Dedicated index 2 (system stack) reaches the live pointer while stack select is 0 and the system bank otherwise; index 3 (user stack) reaches the live pointer while stack select is 1 and the user bank otherwise; reads and writes follow the same routing.
- R8: Dedicated indices 0 (table base), 1 (return pointer), 4 (multiply/divide high) and 5 (multiply/divide low) are plain storage; indices 6 and 7 read zero and writes to them change nothing.
- R9: After reset every status field, both banks, the live pointer and the plain dedicated registers read zero, so the system stack is active.
- R10: Each execute-stage flag enable updates its own flag (bit 0 carry, 1 overflow, 2 zero, 3 negative); an explicit condition-code write in the same cycle (word or byte) overrides all flag updates.
- R11: When the status-word write and a field byte write occur in the same cycle, the status-word write wins for every field.
- R12: In a clock that swaps stacks, live-pointer writes and dedicated writes to indices 2 and 3 are discarded; otherwise a dedicated write routed to the live pointer wins over a live-pointer write in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_we | input | 1 | Full status-word write enable |
| word_wdata | input | 32 | Full status-word write data |
| word_rdata | output | 32 | Packed status word |
| cc_we | input | 1 | Condition-code byte write enable |
| cc_wdata | input | 8 | Condition-code write data |
| cc_rdata | output | 8 | Condition-code byte |
| sc_we | input | 1 | System-condition byte write enable |
| sc_wdata | input | 8 | System-condition write data |
| sc_rdata | output | 8 | System-condition byte |
| lvl_we | input | 1 | Level-mask byte write enable |
| lvl_wdata | input | 8 | Level-mask write data |
| lvl_rdata | output | 8 | Level-mask byte |
| flag_we | input | 4 | Per-flag update enables from execute (carry, overflow, zero, negative) |
| flag_wdata | input | 4 | Per-flag update values |
| dr_we | input | 1 | Dedicated-register write enable |
| dr_sel | input | 3 | Dedicated-register index |
| dr_wdata | input | DW | Dedicated-register write data |
| dr_rdata | output | DW | Dedicated-register read data for dr_sel |
| sp_we | input | 1 | Live stack-pointer write enable from the register file |
| sp_wdata | input | DW | Live stack-pointer write data |
| sp_rdata | output | DW | Live stack-pointer value |

## Verification
A wrong stack-select state or a missed swap shows at once on sp_rdata and on the routing of dedicated indices 2 and 3 in the clock after the offending write, while a corrupted bank stays hidden until the next swap or until its index is read while it is banked. Level-mask mistakes appear on lvl_rdata one clock after the write, but only when a write below 16 meets a mask already at 16 or above, so sequences that climb and then try to descend are driven on purpose. Field masking and packing errors are visible on the byte and word read ports in the clock after any write.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int CC_W     = 6;
  localparam int SC_W     = 3;
  localparam int LVL_W    = 5;
  localparam int FLAG_N   = 4;
  localparam int CC_LSB   = 0;
  localparam int SC_LSB   = 8;
  localparam int LVL_LSB  = 16;
  localparam int BIT_STK  = 5;
  localparam int SEL_W    = 3;
  localparam int PLAIN_N  = 4;

  typedef enum logic [SEL_W-1:0] {
    DR_TBASE = 3'd0,
    DR_RET   = 3'd1,
    DR_SSTK  = 3'd2,
    DR_USTK  = 3'd3,
    DR_MHI   = 3'd4,
    DR_MLO   = 3'd5
  } dr_idx_e;

  // Plain slot numbering inside the storage array
  localparam int SLOT_TBASE = 0;
  localparam int SLOT_RET   = 1;
  localparam int SLOT_MHI   = 2;
  localparam int SLOT_MLO   = 3;
endpackage

// File: rtl/status_fields.sv
module status_fields
  import cpu_status_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_we,
  input  logic [WORD_W-1:0]   word_wdata,
  input  logic                cc_we,
  input  logic [BYTE_W-1:0]   cc_wdata,
  input  logic                sc_we,
  input  logic [BYTE_W-1:0]   sc_wdata,
  input  logic                lvl_we,
  input  logic [BYTE_W-1:0]   lvl_wdata,
  input  logic [FLAG_N-1:0]   flag_we,
  input  logic [FLAG_N-1:0]   flag_wdata,
  output logic [CC_W-1:0]     cc_q,
  output logic [SC_W-1:0]     sc_q,
  output logic [LVL_W-1:0]    lvl_q,
  output logic                stk_swap
);
  logic [CC_W-1:0]  cc_d;
  logic [SC_W-1:0]  sc_d;
  logic [LVL_W-1:0] lvl_d;
  logic [LVL_W-1:0] lvl_raw;
  logic             cc_en, sc_en, lvl_en;
  logic             unused_bits;

  assign unused_bits = ^{word_wdata[WORD_W-1:LVL_LSB+LVL_W],
                         word_wdata[LVL_LSB-1:SC_LSB+SC_W],
                         word_wdata[SC_LSB-1:CC_W],
                         cc_wdata[BYTE_W-1:CC_W],
                         sc_wdata[BYTE_W-1:SC_W],
                         lvl_wdata[BYTE_W-1:LVL_W]};

  assign cc_en  = word_we | cc_we | (|flag_we);
  assign sc_en  = word_we | sc_we;
  assign lvl_en = word_we | lvl_we;

  // Condition codes: execute flags first, explicit writes override
  always_comb begin
    cc_d = cc_q;
    for (int i = 0; i < FLAG_N; i++) begin
      if (flag_we[i]) cc_d[i] = flag_wdata[i];
    end
    if (word_we)     cc_d = word_wdata[CC_LSB +: CC_W];
    else if (cc_we)  cc_d = cc_wdata[CC_W-1:0];
  end

  always_comb begin
    sc_d = sc_q;
    if (word_we)     sc_d = word_wdata[SC_LSB +: SC_W];
    else if (sc_we)  sc_d = sc_wdata[SC_W-1:0];
  end

  // Level mask: once in the upper half, a write cannot leave it
  always_comb begin
    lvl_raw = word_we ? word_wdata[LVL_LSB +: LVL_W] : lvl_wdata[LVL_W-1:0];
    lvl_d   = lvl_raw;
    if (lvl_q[LVL_W-1] && !lvl_raw[LVL_W-1]) lvl_d[LVL_W-1] = 1'b1;
  end

  assign stk_swap = cc_d[BIT_STK] ^ cc_q[BIT_STK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q <= '0;
    end else if (cc_en) begin
      cc_q <= cc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= '0;
    end else if (sc_en) begin
      sc_q <= sc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (lvl_en) begin
      lvl_q <= lvl_d;
    end
  end
endmodule

// File: rtl/stack_bank.sv
module stack_bank #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stk_sel,
  input  logic          stk_swap,
  input  logic          sp_we,
  input  logic [DW-1:0] sp_wdata,
  input  logic          sys_we,
  input  logic          usr_we,
  input  logic [DW-1:0] dr_wdata,
  output logic [DW-1:0] sp_q,
  output logic [DW-1:0] ssp_q,
  output logic [DW-1:0] usp_q,
  output logic [DW-1:0] sys_view,
  output logic [DW-1:0] usr_view
);
  logic [DW-1:0] sp_d, ssp_d, usp_d;
  logic          sp_en, ssp_en, usp_en;

  always_comb begin
    sp_d  = sp_q;
    ssp_d = ssp_q;
    usp_d = usp_q;
    if (stk_swap) begin
      if (stk_sel) begin
        usp_d = sp_q;
        sp_d  = ssp_q;
      end else begin
        ssp_d = sp_q;
        sp_d  = usp_q;
      end
    end else begin
      if (sp_we) sp_d = sp_wdata;
      if (sys_we) begin
        if (stk_sel) ssp_d = dr_wdata;
        else         sp_d  = dr_wdata;
      end
      if (usr_we) begin
        if (stk_sel) sp_d  = dr_wdata;
        else         usp_d = dr_wdata;
      end
    end
  end

  assign sp_en  = stk_swap | sp_we | sys_we | usr_we;
  assign ssp_en = stk_swap | sys_we;
  assign usp_en = stk_swap | usr_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssp_q <= '0;
    end else if (ssp_en) begin
      ssp_q <= ssp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usp_q <= '0;
    end else if (usp_en) begin
      usp_q <= usp_d;
    end
  end

  assign sys_view = stk_sel ? ssp_q : sp_q;
  assign usr_view = stk_sel ? sp_q  : usp_q;
endmodule

// File: rtl/dedicated_store.sv
module dedicated_store #(
  parameter int DW    = 32,
  parameter int SLOTS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SLOTS-1:0]          wr_en,
  input  logic [DW-1:0]             wdata,
  output logic [SLOTS-1:0][DW-1:0]  slot_q
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [DW-1:0] q;
    logic [DW-1:0] d;

    always_comb d = wr_en[g] ? wdata : q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_en[g]) begin
        q <= d;
      end
    end

    assign slot_q[g] = q;
  end
endmodule

// File: rtl/cpu_status_bank.sv
module cpu_status_bank
  import cpu_status_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_we,
  input  logic [31:0]       word_wdata,
  output logic [31:0]       word_rdata,
  input  logic              cc_we,
  input  logic [7:0]        cc_wdata,
  output logic [7:0]        cc_rdata,
  input  logic              sc_we,
  input  logic [7:0]        sc_wdata,
  output logic [7:0]        sc_rdata,
  input  logic              lvl_we,
  input  logic [7:0]        lvl_wdata,
  output logic [7:0]        lvl_rdata,
  input  logic [3:0]        flag_we,
  input  logic [3:0]        flag_wdata,
  input  logic              dr_we,
  input  logic [2:0]        dr_sel,
  input  logic [DW-1:0]     dr_wdata,
  output logic [DW-1:0]     dr_rdata,
  input  logic              sp_we,
  input  logic [DW-1:0]     sp_wdata,
  output logic [DW-1:0]     sp_rdata
);
  logic [CC_W-1:0]              cc_q;
  logic [SC_W-1:0]              sc_q;
  logic [LVL_W-1:0]             lvl_q;
  logic                         stk_swap;
  logic [DW-1:0]                sp_q, ssp_q, usp_q, sys_view, usr_view;
  logic                         sys_we, usr_we;
  logic [PLAIN_N-1:0]           plain_we;
  logic [PLAIN_N-1:0][DW-1:0]   plain_q;

  status_fields u_fields (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_we    (word_we),
    .word_wdata (word_wdata),
    .cc_we      (cc_we),
    .cc_wdata   (cc_wdata),
    .sc_we      (sc_we),
    .sc_wdata   (sc_wdata),
    .lvl_we     (lvl_we),
    .lvl_wdata  (lvl_wdata),
    .flag_we    (flag_we),
    .flag_wdata (flag_wdata),
    .cc_q       (cc_q),
    .sc_q       (sc_q),
    .lvl_q      (lvl_q),
    .stk_swap   (stk_swap)
  );

  // Index decode for dedicated writes
  always_comb begin
    sys_we   = 1'b0;
    usr_we   = 1'b0;
    plain_we = '0;
    if (dr_we) begin
      case (dr_sel)
        DR_TBASE: plain_we[SLOT_TBASE] = 1'b1;
        DR_RET:   plain_we[SLOT_RET]   = 1'b1;
        DR_SSTK:  sys_we               = 1'b1;
        DR_USTK:  usr_we               = 1'b1;
        DR_MHI:   plain_we[SLOT_MHI]   = 1'b1;
        DR_MLO:   plain_we[SLOT_MLO]   = 1'b1;
        default:  ;
      endcase
    end
  end

  stack_bank #(.DW(DW)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .stk_sel  (cc_q[BIT_STK]),
    .stk_swap (stk_swap),
    .sp_we    (sp_we),
    .sp_wdata (sp_wdata),
    .sys_we   (sys_we),
    .usr_we   (usr_we),
    .dr_wdata (dr_wdata),
    .sp_q     (sp_q),
    .ssp_q    (ssp_q),
    .usp_q    (usp_q),
    .sys_view (sys_view),
    .usr_view (usr_view)
  );

  dedicated_store #(.DW(DW), .SLOTS(PLAIN_N)) u_plain (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (plain_we),
    .wdata  (dr_wdata),
    .slot_q (plain_q)
  );

  always_comb begin
    case (dr_sel)
      DR_TBASE: dr_rdata = plain_q[SLOT_TBASE];
      DR_RET:   dr_rdata = plain_q[SLOT_RET];
      DR_SSTK:  dr_rdata = sys_view;
      DR_USTK:  dr_rdata = usr_view;
      DR_MHI:   dr_rdata = plain_q[SLOT_MHI];
      DR_MLO:   dr_rdata = plain_q[SLOT_MLO];
      default:  dr_rdata = '0;
    endcase
  end

  always_comb begin
    word_rdata = '0;
    word_rdata[CC_LSB  +: CC_W]  = cc_q;
    word_rdata[SC_LSB  +: SC_W]  = sc_q;
    word_rdata[LVL_LSB +: LVL_W] = lvl_q;
  end

  assign cc_rdata  = {{(BYTE_W-CC_W){1'b0}}, cc_q};
  assign sc_rdata  = {{(BYTE_W-SC_W){1'b0}}, sc_q};
  assign lvl_rdata = {{(BYTE_W-LVL_W){1'b0}}, lvl_q};
  assign sp_rdata  = sp_q;
endmodule

// File: rtl/cpu_status_chk.sv
module cpu_status_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          word_we,
  input logic [31:0]   word_rdata,
  input logic          cc_we,
  input logic [7:0]    cc_wdata,
  input logic [7:0]    cc_rdata,
  input logic [7:0]    sc_rdata,
  input logic          lvl_we,
  input logic [7:0]    lvl_wdata,
  input logic [7:0]    lvl_rdata,
  input logic          dr_we,
  input logic          sp_we,
  input logic [DW-1:0] sp_rdata,
  input logic [DW-1:0] ssp_q,
  input logic [DW-1:0] usp_q
);
  AST_WORD_GAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rdata[31:21] == '0) && (word_rdata[15:11] == '0) && (word_rdata[7:6] == '0)); // R3

  AST_SC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    sc_rdata[7:3] == '0); // R2

  AST_CC_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && cc_we && !word_we) |-> cc_rdata == {2'b00, $past(cc_wdata[5:0])}); // R10

  AST_LEVEL_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && lvl_we && !word_we && lvl_rdata[4] && !lvl_wdata[4])
      |-> lvl_rdata[4:0] == ($past(lvl_wdata[4:0]) | 5'h10)); // R4

  AST_SWAP_TO_SYSTEM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cc_rdata[5]) |-> (sp_rdata == $past(ssp_q)) && (usp_q == $past(sp_rdata))); // R5

  AST_SWAP_TO_USER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_rdata[5]) |-> (sp_rdata == $past(usp_q)) && (ssp_q == $past(sp_rdata))); // R6

  AST_NO_SWAP_KEEPS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cc_rdata[5]) && $past(rst_n && !sp_we && !dr_we) |-> $stable(sp_rdata)); // R6
endmodule

bind cpu_status_bank cpu_status_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_we    (word_we),
  .word_rdata (word_rdata),
  .cc_we      (cc_we),
  .cc_wdata   (cc_wdata),
  .cc_rdata   (cc_rdata),
  .sc_rdata   (sc_rdata),
  .lvl_we     (lvl_we),
  .lvl_wdata  (lvl_wdata),
  .lvl_rdata  (lvl_rdata),
  .dr_we      (dr_we),
  .sp_we      (sp_we),
  .sp_rdata   (sp_rdata),
  .ssp_q      (ssp_q),
  .usp_q      (usp_q)
);

// File: tb/tb_cpu_status_bank.sv
module tb_cpu_status_bank;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          word_we;
  logic [31:0]   word_wdata;
  logic [31:0]   word_rdata;
  logic          cc_we;
  logic [7:0]    cc_wdata;
  logic [7:0]    cc_rdata;
  logic          sc_we;
  logic [7:0]    sc_wdata;
  logic [7:0]    sc_rdata;
  logic          lvl_we;
  logic [7:0]    lvl_wdata;
  logic [7:0]    lvl_rdata;
  logic [3:0]    flag_we;
  logic [3:0]    flag_wdata;
  logic          dr_we;
  logic [2:0]    dr_sel;
  logic [DW-1:0] dr_wdata;
  logic [DW-1:0] dr_rdata;
  logic          sp_we;
  logic [DW-1:0] sp_wdata;
  logic [DW-1:0] sp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference state
  logic [5:0]    m_cc;
  logic [2:0]    m_sc;
  logic [4:0]    m_lvl;
  logic [DW-1:0] m_sp, m_ssp, m_usp;
  logic [DW-1:0] m_plain [8];

  cpu_status_bank #(.DW(DW)) dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic idle();
    word_we = 0; word_wdata = '0; cc_we = 0; cc_wdata = '0;
    sc_we = 0; sc_wdata = '0; lvl_we = 0; lvl_wdata = '0;
    flag_we = '0; flag_wdata = '0; dr_we = 0; dr_wdata = '0;
    sp_we = 0; sp_wdata = '0;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_dr(input logic [2:0] s);
    case (s)
      3'd2:    return m_cc[5] ? m_ssp : m_sp;
      3'd3:    return m_cc[5] ? m_sp  : m_usp;
      3'd6,
      3'd7:    return '0;
      default: return m_plain[s];
    endcase
  endfunction

  task automatic compare(input string tag);
    check(tag, "cc_rdata",   32'(cc_rdata),  {26'd0, m_cc});
    check(tag, "sc_rdata",   32'(sc_rdata),  {29'd0, m_sc});
    check(tag, "lvl_rdata",  32'(lvl_rdata), {27'd0, m_lvl});
    check(tag, "word_rdata", word_rdata,     {11'd0, m_lvl, 5'd0, m_sc, 2'd0, m_cc});
    check(tag, "sp_rdata",   sp_rdata,       m_sp);
    check(tag, "dr_rdata",   dr_rdata,       exp_dr(dr_sel));
  endtask

  task automatic model_step();
    logic [5:0]    n_cc;
    logic [2:0]    n_sc;
    logic [4:0]    n_lvl;
    logic [4:0]    v;
    logic [DW-1:0] n_sp, n_ssp, n_usp;
    n_cc = m_cc; n_sc = m_sc; n_lvl = m_lvl;
    n_sp = m_sp; n_ssp = m_ssp; n_usp = m_usp;
    for (int i = 0; i < 4; i++) if (flag_we[i]) n_cc[i] = flag_wdata[i];
    if (word_we)     n_cc = word_wdata[5:0];
    else if (cc_we)  n_cc = cc_wdata[5:0];
    if (word_we)     n_sc = word_wdata[10:8];
    else if (sc_we)  n_sc = sc_wdata[2:0];
    if (word_we || lvl_we) begin
      v = word_we ? word_wdata[20:16] : lvl_wdata[4:0];
      if (m_lvl >= 5'd16 && v < 5'd16) v = v + 5'd16;
      n_lvl = v;
    end
    if (n_cc[5] != m_cc[5]) begin
      if (m_cc[5]) begin n_usp = m_sp; n_sp = m_ssp; end
      else         begin n_ssp = m_sp; n_sp = m_usp; end
    end else begin
      if (sp_we) n_sp = sp_wdata;
      if (dr_we && dr_sel == 3'd2) begin
        if (m_cc[5]) n_ssp = dr_wdata; else n_sp = dr_wdata;
      end
      if (dr_we && dr_sel == 3'd3) begin
        if (m_cc[5]) n_sp = dr_wdata; else n_usp = dr_wdata;
      end
    end
    if (dr_we && (dr_sel inside {3'd0, 3'd1, 3'd4, 3'd5})) m_plain[dr_sel] = dr_wdata;
    m_cc = n_cc; m_sc = n_sc; m_lvl = n_lvl;
    m_sp = n_sp; m_ssp = n_ssp; m_usp = n_usp;
  endtask

  // Inputs already driven after a falling edge; compare, advance, clear
  task automatic cyc(input string tag);
    #1;
    compare(tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic look(input string tag, input logic [2:0] s);
    dr_sel = s;
    cyc(tag);
  endtask

  initial begin
    rst_n = 0;
    idle();
    dr_sel = '0;
    m_cc = '0; m_sc = '0; m_lvl = '0; m_sp = '0; m_ssp = '0; m_usp = '0;
    for (int i = 0; i < 8; i++) m_plain[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R9: reset state on every port
    for (int s = 0; s < 8; s++) look("R9", 3'(s));

    // R1: condition-code byte masking and layout
    cc_we = 1; cc_wdata = 8'hFF; cyc("R1");
    cc_we = 1; cc_wdata = 8'hC5; cyc("R1");
    cc_we = 1; cc_wdata = 8'h1A; cyc("R1");

    // R2: system-condition masking
    sc_we = 1; sc_wdata = 8'hFF; cyc("R2");
    sc_we = 1; sc_wdata = 8'hFA; cyc("R2");
    cyc("R2");

    // R3: word packing, all fields in one clock
    word_we = 1; word_wdata = 32'hFFFF_FFFF; cyc("R3");
    word_we = 1; word_wdata = 32'h0000_0000; cyc("R3");
    word_we = 1; word_wdata = 32'hABC5_F21B; cyc("R3");
    word_we = 1; word_wdata = 32'h0000_0000; cyc("R3");

    // R4: level mask write rule
    lvl_we = 1; lvl_wdata = 8'hE7; cyc("R4");
    lvl_we = 1; lvl_wdata = 8'h12; cyc("R4");
    lvl_we = 1; lvl_wdata = 8'h04; cyc("R4");
    lvl_we = 1; lvl_wdata = 8'h1F; cyc("R4");
    word_we = 1; word_wdata = 32'h0002_0000; cyc("R4");
    lvl_we = 1; lvl_wdata = 8'h10; cyc("R4");
    cyc("R4");

    // R6/R5: swap in both directions, same-value writes do not swap
    sp_we = 1; sp_wdata = 32'h0000_1000; cyc("R7");
    dr_we = 1; dr_sel = 3'd3; dr_wdata = 32'h0000_2000; cyc("R7");
    look("R7", 3'd3);
    cc_we = 1; cc_wdata = 8'h20; look("R6", 3'd2);
    look("R6", 3'd2);
    cc_we = 1; cc_wdata = 8'h2F; look("R6", 3'd3);
    sp_we = 1; sp_wdata = 32'h0000_2222; cyc("R6");
    cc_we = 1; cc_wdata = 8'h00; look("R5", 3'd3);
    look("R5", 3'd3);
    look("R5", 3'd2);

    // R7: routing of stack indices in both modes
    dr_we = 1; dr_sel = 3'd2; dr_wdata = 32'h5555_0002; cyc("R7");
    dr_we = 1; dr_sel = 3'd3; dr_wdata = 32'h5555_0003; cyc("R7");
    look("R7", 3'd2); look("R7", 3'd3);
    word_we = 1; word_wdata = 32'h0000_0020; look("R7", 3'd2);
    dr_we = 1; dr_sel = 3'd2; dr_wdata = 32'h6666_0002; cyc("R7");
    dr_we = 1; dr_sel = 3'd3; dr_wdata = 32'h6666_0003; cyc("R7");
    look("R7", 3'd2); look("R7", 3'd3);

    // R8: plain dedicated storage and unused indices
    for (int s = 0; s < 8; s++) begin
      dr_we = 1; dr_sel = 3'(s); dr_wdata = 32'hA000_0000 | 32'(s); cyc("R8");
    end
    for (int s = 0; s < 8; s++) look("R8", 3'(s));

    // R10: execute flag updates alone and against explicit writes
    flag_we = 4'b0101; flag_wdata = 4'b1111; cyc("R10");
    flag_we = 4'b1010; flag_wdata = 4'b1010; cyc("R10");
    flag_we = 4'b0011; flag_wdata = 4'b0000; cyc("R10");
    flag_we = 4'b1111; flag_wdata = 4'b1111; cc_we = 1; cc_wdata = 8'h20; cyc("R10");
    flag_we = 4'b1111; flag_wdata = 4'b0000; word_we = 1; word_wdata = 32'h0000_002F; cyc("R10");
    cyc("R10");

    // R11: word write beats byte field writes
    word_we = 1; word_wdata = 32'h0013_0105; cc_we = 1; cc_wdata = 8'h3A;
    sc_we = 1; sc_wdata = 8'h06; lvl_we = 1; lvl_wdata = 8'h1E; cyc("R11");
    cyc("R11");

    // R12: writes discarded during a swap, dr beats sp_we otherwise
    sp_we = 1; sp_wdata = 32'h7777_0000;
    dr_we = 1; dr_sel = 3'd3; dr_wdata = 32'h8888_0000;
    cc_we = 1; cc_wdata = 8'h00; cyc("R12");
    look("R12", 3'd3); look("R12", 3'd2);
    sp_we = 1; sp_wdata = 32'h7777_1111;
    dr_we = 1; dr_sel = 3'd2; dr_wdata = 32'h8888_1111; cyc("R12");
    cyc("R12");
    sp_we = 1; sp_wdata = 32'h7777_2222;
    dr_we = 1; dr_sel = 3'd2; dr_wdata = 32'h8888_2222;
    word_we = 1; word_wdata = 32'h0010_0020; cyc("R12");
    look("R12", 3'd2); look("R12", 3'd3);

    // Mixed traffic
    for (int n = 0; n < 2000; n++) begin
      word_we    = ($urandom % 10) == 0;
      word_wdata = $urandom;
      cc_we      = ($urandom % 6) == 0;
      cc_wdata   = 8'($urandom);
      sc_we      = ($urandom % 8) == 0;
      sc_wdata   = 8'($urandom);
      lvl_we     = ($urandom % 5) == 0;
      lvl_wdata  = 8'($urandom);
      flag_we    = 4'($urandom);
      flag_wdata = 4'($urandom);
      dr_we      = ($urandom % 3) == 0;
      dr_sel     = 3'($urandom);
      dr_wdata   = $urandom;
      sp_we      = ($urandom % 3) == 0;
      sp_wdata   = $urandom;
      cyc("R12");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule